// File: doc/BRIEF.md
# Multiplexed Bus Slave Interface

This block is the host-side front end of a byte-wide memory peripheral that sits on a microcontroller's shared address/data bus. The host puts the low address byte on the shared 8-bit bus and the upper 5 address bits on separate pins. It then pulses the address-latch strobe. When that strobe falls, the block freezes the 13-bit address and decides whether the device is selected. After that, one of three active-low strobes (program fetch, data read or write) picks the bus cycle. For a read cycle the block turns on the bus driver and forwards the byte that the storage core returns for the latched address. For a write cycle it captures the bus byte when the write strobe ends.

Every bus input comes from outside the chip clock domain. All of them pass through a bank of synchronizer flops of the same depth, so the address, data and strobes stay aligned. After that, strobe edges are detected with one register per strobe. The storage core behind the block gets the latched address, the decoded cycle type, and a one-cycle write pulse carrying the captured byte.

Top module: `muxbus_slave_if`

## Requirements
- R1: While the latch strobe `ale` is high, `addr` follows `{addr_hi, ad_in}` within SYNC_STAGES+1 clock cycles.
- R2: Once `ale` has fallen, `addr` keeps the last value seen while the strobe was high, however `ad_in` and `addr_hi` change afterwards.
- R3: The device counts as selected only if `cs_n` was low when `ale` fell. If `cs_n` was high at that edge, a later low `cs_n` does not select the device.
- R4: While `cs_n` is high, `mode` is STANDBY, `ad_oe` is low and no write pulse is issued.
- R5: Program fetch (`fetch_n` low, `rd_n` and `wr_n` high, device selected) gives `mode` FETCH, raises `ad_oe` and drives `ad_out` with `core_rdata`.
- R6: Data read (`rd_n` low, `fetch_n` and `wr_n` high, device selected) gives `mode` READ, raises `ad_oe` and drives `ad_out` with `core_rdata`.
- R7: Conflicting strobes (`fetch_n` and `rd_n` both low, or `wr_n` and `rd_n` both low) give `mode` IDLE, with the bus released and no write.
- R8: A selected write (`wr_n` low, `rd_n` high) produces exactly one `wr_pulse` cycle after `wr_n` rises. `wr_data` then holds the `ad_in` byte that was present when `wr_n` rose.
- R9: A write pulse is issued only if `wc_n` was low while the write strobe was still low. With `wc_n` high, writes have no effect.
- R10: After reset, `addr` is 0, `ad_oe` is low, `wr_pulse` is low and `mode` is STANDBY.
- R11: `mode` encodes STANDBY=0, IDLE=1, FETCH=2, READ=3, WRITE=4, and `ad_oe` is high only in FETCH or READ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address latch strobe, active high; the address is held from its falling edge |
| cs_n | input | 1 | Chip select, active low, sampled at the falling edge of `ale` |
| fetch_n | input | 1 | Program-fetch read strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; data is taken on its rising edge |
| wc_n | input | 1 | Write enable, active low; held high, it blocks all writes |
| addr_hi | input | 5 | Upper address bits |
| ad_in | input | 8 | Shared bus, input side: low address byte or write data |
| ad_out | output | 8 | Shared bus, output side: read data |
| ad_oe | output | 1 | Bus driver enable for `ad_out` |
| core_rdata | input | 8 | Byte returned by the storage core for `addr` |
| addr | output | 13 | Latched address |
| mode | output | 3 | Decoded cycle type |
| wr_pulse | output | 1 | One-cycle write request to the storage core |
| wr_data | output | 8 | Captured write byte |

## Verification
The properties assume the host behaves like a real multiplexed bus master. The address is stable across the falling edge of `ale`. Write data stays on the bus until after `wr_n` has risen. No strobe changes faster than the synchronizer depth can follow. The bench drives all pins on the falling clock edge and holds each phase of a bus cycle for several clocks: latch, hold, strobe and release. It also leaves `wc_n` low until the write strobe has been released, so every edge reaches the synchronized domain cleanly and in the intended order. The conflict vectors break only the rule on strobe combinations and keep all timing legal.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

   typedef enum logic [2:0] {
      MB_STANDBY = 3'd0,
      MB_IDLE    = 3'd1,
      MB_FETCH   = 3'd2,
      MB_READ    = 3'd3,
      MB_WRITE   = 3'd4
   } mb_mode_e;

   // Priority: not selected -> standby; then exact strobe combinations.
   function automatic mb_mode_e mb_decode(input logic selected,
                                          input logic fetch_n,
                                          input logic rd_n,
                                          input logic wr_n);
      mb_mode_e m;
      if (!selected)
         m = MB_STANDBY;
      else if (!fetch_n && rd_n && wr_n)
         m = MB_FETCH;
      else if (fetch_n && !rd_n && wr_n)
         m = MB_READ;
      else if (!wr_n && rd_n)
         m = MB_WRITE;
      else
         m = MB_IDLE;
      return m;
   endfunction

   function automatic logic mb_is_read(input mb_mode_e m);
      return (m == MB_FETCH) || (m == MB_READ);
   endfunction

endpackage

// File: rtl/mbs_sync_bank.sv
module mbs_sync_bank #(
   parameter int unsigned  W          = 8,
   parameter int unsigned  STAGES     = 2,
   parameter logic [W-1:0] RESET_VAL  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("mbs_sync_bank: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("mbs_sync_bank: W must be positive");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RESET_VAL;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RESET_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/mbs_addr_latch.sv
module mbs_addr_latch #(
   parameter int unsigned ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ale_s,
   input  logic              cs_n_s,
   input  logic [ADDR_W-1:0] bus_s,
   output logic [ADDR_W-1:0] addr_q,
   output logic              sel_q
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("mbs_addr_latch: ADDR_W too small");
   end

   logic ale_p;
   logic ale_fall;

   assign ale_fall = ale_p && !ale_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ale_p <= 1'b0;
      else        ale_p <= ale_s;
   end

   // Address tracks the bus while the strobe is high and freezes after it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     addr_q <= '0;
      else if (ale_s) addr_q <= bus_s;
   end

   // Select is taken only at the strobe's falling edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sel_q <= 1'b0;
      else if (ale_fall) sel_q <= !cs_n_s;
   end

endmodule

// File: rtl/mbs_mode_decode.sv
module mbs_mode_decode
   import muxbus_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sel_q,
   input  logic     cs_n_s,
   input  logic     fetch_n_s,
   input  logic     rd_n_s,
   input  logic     wr_n_s,
   output mb_mode_e mode_q
);

   logic selected;

   assign selected = sel_q && !cs_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MB_STANDBY;
      else        mode_q <= mb_decode(selected, fetch_n_s, rd_n_s, wr_n_s);
   end

endmodule

// File: rtl/mbs_wr_capture.sv
module mbs_wr_capture
   import muxbus_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n_s,
   input  logic              wc_n_s,
   input  mb_mode_e          mode_q,
   input  logic [DATA_W-1:0] data_s,
   output logic              wr_pulse,
   output logic [DATA_W-1:0] wr_data
);

   logic wr_n_p;
   logic wc_n_p;
   logic wr_rise;
   logic take;

   assign wr_rise = !wr_n_p && wr_n_s;
   // mode_q still reflects the cycle in which the strobe was low.
   assign take    = wr_rise && (mode_q == MB_WRITE) && !wc_n_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_n_p <= 1'b1;
         wc_n_p <= 1'b1;
      end else begin
         wr_n_p <= wr_n_s;
         wc_n_p <= wc_n_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_pulse <= 1'b0;
         wr_data  <= '0;
      end else begin
         wr_pulse <= take;
         if (take) wr_data <= data_s;
      end
   end

endmodule

// File: rtl/muxbus_slave_if.sv
module muxbus_slave_if
   import muxbus_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned ADDR_HI_W     = 5,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          READ_DATA_REG = 1'b0,
   localparam int unsigned ADDR_W       = DATA_W + ADDR_HI_W,
   localparam int unsigned N_STROBE     = 6,
   localparam int unsigned SYNC_W       = N_STROBE + ADDR_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ale,
   input  logic                 cs_n,
   input  logic                 fetch_n,
   input  logic                 rd_n,
   input  logic                 wr_n,
   input  logic                 wc_n,
   input  logic [ADDR_HI_W-1:0] addr_hi,
   input  logic [DATA_W-1:0]    ad_in,
   output logic [DATA_W-1:0]    ad_out,
   output logic                 ad_oe,
   input  logic [DATA_W-1:0]    core_rdata,
   output logic [ADDR_W-1:0]    addr,
   output logic [2:0]           mode,
   output logic                 wr_pulse,
   output logic [DATA_W-1:0]    wr_data
);

   if (DATA_W < 1 || ADDR_HI_W < 1) begin : g_bad_widths
      $error("muxbus_slave_if: widths must be positive");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("muxbus_slave_if: SYNC_STAGES must be at least 2");
   end

   // Strobes idle: ale low, active-low strobes high; bus bits reset to 0.
   localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 5'b11111, {ADDR_W{1'b0}}};

   logic [SYNC_W-1:0] raw_v;
   logic [SYNC_W-1:0] syn_v;
   logic              s_ale, s_cs_n, s_fetch_n, s_rd_n, s_wr_n, s_wc_n;
   logic [ADDR_W-1:0] s_bus;
   logic [ADDR_W-1:0] addr_q;
   logic              sel_q;
   mb_mode_e          mode_q;

   assign raw_v = {ale, cs_n, fetch_n, rd_n, wr_n, wc_n, addr_hi, ad_in};
   assign {s_ale, s_cs_n, s_fetch_n, s_rd_n, s_wr_n, s_wc_n, s_bus} = syn_v;

   mbs_sync_bank #(
      .W         (SYNC_W),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_v),
      .q     (syn_v)
   );

   mbs_addr_latch #(
      .ADDR_W (ADDR_W)
   ) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .ale_s  (s_ale),
      .cs_n_s (s_cs_n),
      .bus_s  (s_bus),
      .addr_q (addr_q),
      .sel_q  (sel_q)
   );

   mbs_mode_decode u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_q     (sel_q),
      .cs_n_s    (s_cs_n),
      .fetch_n_s (s_fetch_n),
      .rd_n_s    (s_rd_n),
      .wr_n_s    (s_wr_n),
      .mode_q    (mode_q)
   );

   mbs_wr_capture #(
      .DATA_W (DATA_W)
   ) u_wcap (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_n_s   (s_wr_n),
      .wc_n_s   (s_wc_n),
      .mode_q   (mode_q),
      .data_s   (s_bus[DATA_W-1:0]),
      .wr_pulse (wr_pulse),
      .wr_data  (wr_data)
   );

   assign addr  = addr_q;
   assign mode  = mode_q;
   assign ad_oe = mb_is_read(mode_q);

   if (READ_DATA_REG) begin : g_rdata_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= core_rdata;
      end
      assign ad_out = ad_oe ? rd_q : '0;
   end else begin : g_rdata_comb
      assign ad_out = ad_oe ? core_rdata : '0;
   end

endmodule

// File: rtl/muxbus_slave_if_chk.sv
module muxbus_slave_if_chk #(
   parameter int unsigned ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_ale,
   input logic              s_cs_n,
   input logic              s_wc_n,
   input logic              sel_q,
   input logic [ADDR_W-1:0] addr,
   input logic [2:0]        mode,
   input logic              ad_oe,
   input logic              wr_pulse
);

   // R2: with the latch strobe low for two cycles the address is frozen.
   a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_ale && $past(!s_ale)) |-> $stable(addr));

   // R3: any active cycle needs select captured at the strobe edge and cs low.
   a_r3_active_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (mode >= 3'd2) |-> ($past(sel_q) && $past(!s_cs_n)));

   // R4: chip select high releases the bus one cycle later.
   a_r4_standby_release: assert property (@(posedge clk) disable iff (!rst_n)
      $past(s_cs_n) |-> !ad_oe);

   // R7: driving the bus and writing never coincide.
   a_r7_no_drive_and_write: assert property (@(posedge clk) disable iff (!rst_n)
      !(ad_oe && wr_pulse));

   // R8: the write request lasts exactly one cycle.
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |=> !wr_pulse);

   // R9: a write request requires the write enable low while the strobe was low.
   a_r9_wc_gate: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |-> $past(!s_wc_n, 2));

   // R11: the bus driver is on only in a read mode.
   a_r11_oe_mode: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> (mode == 3'd2 || mode == 3'd3));

endmodule

bind muxbus_slave_if muxbus_slave_if_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .s_ale    (s_ale),
   .s_cs_n   (s_cs_n),
   .s_wc_n   (s_wc_n),
   .sel_q    (sel_q),
   .addr     (addr),
   .mode     (mode),
   .ad_oe    (ad_oe),
   .wr_pulse (wr_pulse)
);

// File: tb/muxbus_slave_if_test.sv
module muxbus_slave_if_test;

   localparam int unsigned MAX_CYC = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ale = 1'b0;
   logic        cs_n = 1'b1;
   logic        fetch_n = 1'b1;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        wc_n = 1'b1;
   logic [4:0]  addr_hi = '0;
   logic [7:0]  ad_in = '0;
   logic [7:0]  ad_out;
   logic        ad_oe;
   logic [7:0]  core_rdata;
   logic [12:0] addr;
   logic [2:0]  mode;
   logic        wr_pulse;
   logic [7:0]  wr_data;

   int checks = 0;
   int failures = 0;
   int pulses = 0;
   logic [7:0] last_wdata = '0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   muxbus_slave_if uut (
      .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .fetch_n(fetch_n),
      .rd_n(rd_n), .wr_n(wr_n), .wc_n(wc_n), .addr_hi(addr_hi), .ad_in(ad_in),
      .ad_out(ad_out), .ad_oe(ad_oe), .core_rdata(core_rdata), .addr(addr),
      .mode(mode), .wr_pulse(wr_pulse), .wr_data(wr_data)
   );

   // Storage core model: byte content derived from the address.
   function automatic logic [7:0] core_byte(input logic [12:0] a);
      return a[7:0] ^ {a[12:8], 3'b101};
   endfunction
   assign core_rdata = core_byte(addr);

   always @(negedge clk) begin
      if (wr_pulse) begin
         pulses++;
         last_wdata = wr_data;
      end
   end

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // op: 0 fetch, 1 read, 2 write, 3 fetch+read conflict, 4 write+read conflict
   typedef struct packed {
      logic [2:0]  op;
      logic        cs_lvl;
      logic        wc_lvl;
      logic [12:0] a;
      logic [7:0]  d;
      logic        exp_oe;
      logic        exp_wr;
      logic [2:0]  exp_mode;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{3'd0, 1'b0, 1'b1, 13'h0123, 8'h00, 1'b1, 1'b0, 3'd2, 4'd5},  // R5 fetch
      '{3'd1, 1'b0, 1'b1, 13'h1ABC, 8'h00, 1'b1, 1'b0, 3'd3, 4'd6},  // R6 read
      '{3'd2, 1'b0, 1'b0, 13'h0400, 8'hA5, 1'b0, 1'b1, 3'd4, 4'd8},  // R8 write
      '{3'd2, 1'b0, 1'b1, 13'h1FFF, 8'h3C, 1'b0, 1'b0, 3'd4, 4'd9},  // R9 blocked
      '{3'd0, 1'b1, 1'b1, 13'h0055, 8'h00, 1'b0, 1'b0, 3'd0, 4'd4},  // R4 standby fetch
      '{3'd2, 1'b1, 1'b0, 13'h0066, 8'h77, 1'b0, 1'b0, 3'd0, 4'd4},  // R4 standby write
      '{3'd3, 1'b0, 1'b1, 13'h0AAA, 8'h00, 1'b0, 1'b0, 3'd1, 4'd7},  // R7 fetch+read
      '{3'd4, 1'b0, 1'b0, 13'h0555, 8'h99, 1'b0, 1'b0, 3'd1, 4'd7},  // R7 write+read
      '{3'd1, 1'b0, 1'b1, 13'h0000, 8'h00, 1'b1, 1'b0, 3'd3, 4'd6},  // R6 lowest address
      '{3'd2, 1'b0, 1'b0, 13'h1FFF, 8'hFF, 1'b0, 1'b1, 3'd4, 4'd8}   // R8 highest address
   };

   task automatic latch_addr(input logic cs_lvl, input logic [12:0] a);
      cs_n = cs_lvl; ale = 1'b1;
      ad_in = a[7:0]; addr_hi = a[12:8];
      wait_neg(5);
      check("R1 flow-through", 16'(addr), 16'(a));
      ale = 1'b0;
      wait_neg(4);
      ad_in = ~a[7:0]; addr_hi = ~a[12:8];
      wait_neg(5);
      check("R2 address held", 16'(addr), 16'(a));
   endtask

   task automatic run_vec(input vec_t v);
      string tag;
      int p0;
      tag = $sformatf("R%0d vector", v.req);
      p0 = pulses;
      latch_addr(v.cs_lvl, v.a);
      wc_n = v.wc_lvl;
      case (v.op)
         3'd0: fetch_n = 1'b0;
         3'd1: rd_n = 1'b0;
         3'd2: begin wr_n = 1'b0; ad_in = v.d; end
         3'd3: begin fetch_n = 1'b0; rd_n = 1'b0; end
         default: begin wr_n = 1'b0; rd_n = 1'b0; ad_in = v.d; end
      endcase
      wait_neg(6);
      check({tag, " mode"}, 16'(mode), 16'(v.exp_mode));
      check({tag, " oe"}, 16'(ad_oe), 16'(v.exp_oe));
      if (v.exp_oe) check({tag, " data"}, 16'(ad_out), 16'(core_byte(v.a)));
      fetch_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      wait_neg(6);
      wc_n = 1'b1;
      check({tag, " released"}, 16'(ad_oe), 16'd0);
      check({tag, " pulses"}, 16'(pulses - p0), 16'(v.exp_wr));
      if (v.exp_wr) check({tag, " wdata"}, 16'(last_wdata), 16'(v.d));
      cs_n = 1'b1;
      wait_neg(4);
   endtask

   initial begin
      wait_neg(3);
      // R10 reset state, R11 standby code 0
      check("R10 addr", 16'(addr), 16'd0);
      check("R10 oe", 16'(ad_oe), 16'd0);
      check("R10 wr_pulse", 16'(wr_pulse), 16'd0);
      check("R11 reset mode", 16'(mode), 16'd0);
      rst_n = 1'b1;
      wait_neg(4);

      for (int i = 0; i < NV; i++) run_vec(VEC[i]);

      // R3: cs high at latch edge, lowered afterwards, must not select
      begin
         int p0;
         p0 = pulses;
         latch_addr(1'b1, 13'h0321);
         cs_n = 1'b0;
         wait_neg(4);
         rd_n = 1'b0;
         wait_neg(6);
         check("R3 late select mode", 16'(mode), 16'd0);
         check("R3 late select oe", 16'(ad_oe), 16'd0);
         rd_n = 1'b1;
         wc_n = 1'b0; wr_n = 1'b0; ad_in = 8'h5A;
         wait_neg(6);
         wr_n = 1'b1;
         wait_neg(6);
         wc_n = 1'b1;
         check("R3 late select no write", 16'(pulses - p0), 16'd0);
         cs_n = 1'b1;
         wait_neg(4);
      end

      // R4: chip select raised in the middle of a read releases the bus
      latch_addr(1'b0, 13'h0F0F);
      rd_n = 1'b0;
      wait_neg(6);
      check("R6 read before deselect", 16'(ad_oe), 16'd1);
      cs_n = 1'b1;
      wait_neg(6);
      check("R4 deselect mid-read oe", 16'(ad_oe), 16'd0);
      check("R4 deselect mid-read mode", 16'(mode), 16'd0);
      rd_n = 1'b1;
      wait_neg(4);

      // R8: a long write strobe still yields one pulse
      begin
         int p0;
         p0 = pulses;
         latch_addr(1'b0, 13'h0777);
         wc_n = 1'b0; wr_n = 1'b0; ad_in = 8'hC3;
         wait_neg(40);
         wr_n = 1'b1;
         wait_neg(6);
         wc_n = 1'b1;
         check("R8 long strobe one pulse", 16'(pulses - p0), 16'd1);
         check("R8 long strobe data", 16'(last_wdata), 16'hC3);
         cs_n = 1'b1;
         wait_neg(4);
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int c = 0; c < MAX_CYC; c++) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule